// File: doc/BRIEF.md
# Cross-Clock Mailbox Register with Occupancy Flag

This block moves a single data word from a writing port to a reading port. The word travels outside the FIFO path, and the two ports run on independent clocks. A write on the writing port with the mailbox select high places the word in a holding register. The writing side then drops its `wr_mail_empty` flag and refuses further mailbox writes. The read side raises `rd_mail_valid` once it learns of the new word. A read on the reading port with its mailbox select high consumes the word. That read clears `rd_mail_valid` and, some cycles later, returns `wr_mail_empty` high on the writing side.

Each domain has a two-state machine. On the writing side, `WR_OPEN` moves to `WR_LOCKED` on a mailbox store (transition *store*). It moves back on an acknowledge event (transition *release*). On the reading side, `RD_EMPTY` moves to `RD_FULL` on a request event (transition *arrive*). It moves back on a consuming read (transition *take*). Events cross between the domains as toggles, each through its own synchronizer of `SYNC_STAGES` flops.

The reading port also contains the output multiplexer. It selects either the mailbox word or the FIFO output register (`fifo_q`).

Top module: `xdom_mailbox`

## Requirements
- R1: A write-clock edge with `wr_en`=1, `wr_mb_sel`=1 and `wr_mail_empty`=1 loads `wr_data` into the mail register.
- R2: The edge that loads the mail register drives `wr_mail_empty` low.
- R3: While `wr_mail_empty` is 0, mailbox writes are refused and the mail register keeps its word.
- R4: `rd_mail_valid` rises on the read-clock edge `SYNC_STAGES`+1 edges after the storing write edge.
- R5: A read-clock edge with `rd_en`=1, `rd_mb_sel`=1 and `rd_mail_valid`=1 drops `rd_mail_valid`. `wr_mail_empty` then rises `SYNC_STAGES`+1 write-clock edges after that read edge.
- R6: A read with `rd_mb_sel`=0, or any read while `rd_mail_valid`=0, consumes nothing.
- R7: `rd_data` equals the mail register when `rd_mb_sel`=1 and `fifo_q` when `rd_mb_sel`=0, with no clock delay.
- R8: While `rst_n`=0 and after it, `wr_mail_empty`=1, `rd_mail_valid`=0, and the mail register holds zero.
- R9: A write with `wr_mb_sel`=0 (a FIFO write) leaves the mail register and `wr_mail_empty` unchanged.
- R10: `rd_mail_valid`=1 never coincides with `wr_mail_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writing-port clock |
| rd_clk | input | 1 | Reading-port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the associated FIFO, shared by both domains |
| wr_en | input | 1 | Qualified write strobe on the writing port |
| wr_mb_sel | input | 1 | Routes the write to the mailbox instead of the FIFO |
| wr_data | input | DATA_W | Write data |
| wr_mail_empty | output | 1 | High when the mailbox can accept a word (write domain) |
| rd_en | input | 1 | Qualified read strobe on the reading port |
| rd_mb_sel | input | 1 | Selects the mailbox for the read and for `rd_data` |
| fifo_q | input | DATA_W | FIFO output register contents |
| rd_data | output | DATA_W | Read data: the mailbox word or `fifo_q` |
| rd_mail_valid | output | 1 | High when an unread word is waiting (read domain) |

## Verification
The bench builds the block with `DATA_W`=36 and `SYNC_STAGES`=2. Both ports run from one 100 MHz clock, which is the coincident-clock case. With a fixed clock relation, every handshake has an exact latency of three edges in each direction. The reference model can therefore predict the cycle on which `rd_mail_valid` rises and the cycle on which `wr_mail_empty` returns high. It can also catch a refused write, a stray consume, or a release that lands one edge early or late. Continuous write and read pressure keeps the handshake cycling at its maximum rate. A reset taken while a word is in flight checks that both flags recover.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    typedef enum logic {
        WR_OPEN   = 1'b0,
        WR_LOCKED = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_EMPTY = 1'b0,
        RD_FULL  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/xmb_toggle_sync.sv
module xmb_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xmb_wr_port.sv
module xmb_wr_port
    import xmb_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              mb_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              ack_sync,
    output logic [DATA_W-1:0] mail_q,
    output logic              req_tog,
    output logic              mail_empty
);

    wr_state_e state, state_nx;
    logic      ack_seen;
    logic      ack_evt;
    logic      store;

    assign ack_evt = ack_sync ^ ack_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_OPEN;
        else        state <= state_nx;
    end

    // transitions: store (OPEN->LOCKED), release (LOCKED->OPEN)
    always_comb begin
        state_nx = state;
        unique case (state)
            WR_OPEN:   if (store)   state_nx = WR_LOCKED;
            WR_LOCKED: if (ack_evt) state_nx = WR_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        mail_empty = (state == WR_OPEN);
        store      = mail_empty && wr_en && mb_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mail_q   <= '0;
            req_tog  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ack_sync;
            if (store) begin
                mail_q  <= din;
                req_tog <= ~req_tog;
            end
        end
    end

endmodule

// File: rtl/xmb_rd_port.sv
module xmb_rd_port
    import xmb_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              mb_sel,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] mail_q,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_tog,
    output logic              mail_valid
);

    rd_state_e state, state_nx;
    logic      req_seen;
    logic      req_evt;
    logic      take;

    assign req_evt = req_sync ^ req_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_EMPTY;
        else        state <= state_nx;
    end

    // transitions: arrive (EMPTY->FULL), take (FULL->EMPTY)
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_EMPTY: if (req_evt) state_nx = RD_FULL;
            RD_FULL:  if (take)    state_nx = RD_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        mail_valid = (state == RD_FULL);
        take       = mail_valid && rd_en && mb_sel;
        rd_data    = mb_sel ? mail_q : fifo_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            ack_tog  <= 1'b0;
        end else begin
            req_seen <= req_sync;
            if (take) ack_tog <= ~ack_tog;
        end
    end

endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_mb_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_mail_empty,
    input  logic              rd_en,
    input  logic              rd_mb_sel,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mail_valid
);

    logic [DATA_W-1:0] mail_q;
    logic              req_tog;
    logic              req_sync;
    logic              ack_tog;
    logic              ack_sync;

    xmb_wr_port #(.DATA_W(DATA_W)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .mb_sel     (wr_mb_sel),
        .din        (wr_data),
        .ack_sync   (ack_sync),
        .mail_q     (mail_q),
        .req_tog    (req_tog),
        .mail_empty (wr_mail_empty)
    );

    xmb_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (req_tog),
        .q     (req_sync)
    );

    xmb_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (ack_tog),
        .q     (ack_sync)
    );

    xmb_rd_port #(.DATA_W(DATA_W)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .mb_sel     (rd_mb_sel),
        .req_sync   (req_sync),
        .mail_q     (mail_q),
        .fifo_q     (fifo_q),
        .rd_data    (rd_data),
        .ack_tog    (ack_tog),
        .mail_valid (rd_mail_valid)
    );

endmodule

// File: rtl/xdom_mailbox_chk.sv
module xdom_mailbox_chk #(
    parameter int DATA_W = 36
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_mb_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_mail_empty,
    input logic              rd_en,
    input logic              rd_mb_sel,
    input logic              rd_mail_valid,
    input logic [DATA_W-1:0] mail_q
);

    assert_store_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && wr_mb_sel && wr_mail_empty) |=> (mail_q == $past(wr_data)));

    assert_flag_low_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && wr_mb_sel && wr_mail_empty) |=> !wr_mail_empty);

    assert_locked_hold_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_mail_empty |=> $stable(mail_q));

    assert_consume_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_mail_valid && rd_en && rd_mb_sel) |=> !rd_mail_valid);

    assert_no_consume_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_mail_valid && !(rd_en && rd_mb_sel)) |=> rd_mail_valid);

    assert_exclusive_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_mail_valid |-> !wr_mail_empty);

endmodule

bind xdom_mailbox xdom_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .wr_clk        (wr_clk),
    .rd_clk        (rd_clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_mb_sel     (wr_mb_sel),
    .wr_data       (wr_data),
    .wr_mail_empty (wr_mail_empty),
    .rd_en         (rd_en),
    .rd_mb_sel     (rd_mb_sel),
    .rd_mail_valid (rd_mail_valid),
    .mail_q        (mail_q)
);

// File: tb/xdom_mailbox_bench.sv
module xdom_mailbox_bench;

    localparam int W = 36;
    localparam int S = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, wr_mb_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0, rd_mb_sel = 1'b0;
    logic [W-1:0] fifo_q = '0;
    logic         wr_mail_empty, rd_mail_valid;
    logic [W-1:0] rd_data;

    always #5 clk = ~clk;

    xdom_mailbox #(.DATA_W(W), .SYNC_STAGES(S)) u_xdom_mailbox (
        .wr_clk        (clk),
        .rd_clk        (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_mb_sel     (wr_mb_sel),
        .wr_data       (wr_data),
        .wr_mail_empty (wr_mail_empty),
        .rd_en         (rd_en),
        .rd_mb_sel     (rd_mb_sel),
        .fifo_q        (fifo_q),
        .rd_data       (rd_data),
        .rd_mail_valid (rd_mail_valid)
    );

    int n_chk = 0;
    int n_err = 0;
    int wd    = 0;
    bit done  = 0;

    // behavioural reference model
    bit           m_flag  = 1;
    bit           m_valid = 0;
    logic [W-1:0] m_mail  = '0;
    int           cyc     = 0;
    int           valid_at = -1;
    int           flag_at  = -1;
    bit           aw, ar;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 1; m_valid = 0; m_mail = '0;
            valid_at = -1; flag_at = -1;
        end else begin
            cyc++;
            aw = m_flag && wr_en && wr_mb_sel;
            ar = m_valid && rd_en && rd_mb_sel;
            if (valid_at == cyc) begin m_valid = 1; valid_at = -1; end
            if (flag_at == cyc)  begin m_flag = 1;  flag_at = -1;  end
            if (aw) begin m_flag = 0; m_mail = wr_data; valid_at = cyc + S + 1; end
            if (ar) begin m_valid = 0; flag_at = cyc + S + 1; end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from both clock edges
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(wr_mail_empty == m_flag, "R2 R5 wr_mail_empty",
                  W'(wr_mail_empty), W'(m_flag));
            check(rd_mail_valid == m_valid, "R4 R6 rd_mail_valid",
                  W'(rd_mail_valid), W'(m_valid));
            check(rd_data == (rd_mb_sel ? m_mail : fifo_q), "R7 R1 R3 rd_data",
                  rd_data, rd_mb_sel ? m_mail : fifo_q);
            check(!(rd_mail_valid && wr_mail_empty), "R10 exclusive flags",
                  W'({rd_mail_valid, wr_mail_empty}), W'(2'b01));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected<=20000", wd);
            finish_run();
        end
    end

    task automatic idle();
        wr_en = 0; wr_mb_sel = 0; rd_en = 0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 30 && !rd_mail_valid; i++) @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 30 && !wr_mail_empty; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        rd_mb_sel = 1;
        #1;
        // R8: reset values visible during reset
        check(wr_mail_empty == 1, "R8 flag in reset", W'(wr_mail_empty), W'(1));
        check(rd_mail_valid == 0, "R8 valid in reset", W'(rd_mail_valid), W'(0));
        check(rd_data == '0, "R8 mail in reset", rd_data, '0);
        @(negedge clk); rst_n = 1;

        // R9: FIFO write leaves the mailbox alone
        fifo_q = 36'h0_1234_5678;
        wr_en = 1; wr_mb_sel = 0; wr_data = 36'hA_AAAA_AAAA;
        @(negedge clk); idle(); #1;
        check(wr_mail_empty == 1, "R9 flag after fifo write", W'(wr_mail_empty), W'(1));
        check(rd_data == '0, "R9 mail after fifo write", rd_data, '0);

        // R1/R2/R4: store a word, count latency to valid
        wr_en = 1; wr_mb_sel = 1; wr_data = 36'h1_1111_2222;
        @(negedge clk); idle(); #1;
        check(wr_mail_empty == 0, "R2 flag low after store", W'(wr_mail_empty), W'(0));
        check(rd_data == 36'h1_1111_2222, "R1 stored word", rd_data, 36'h1_1111_2222);
        repeat (S) @(negedge clk);
        #1;
        check(rd_mail_valid == 0, "R4 valid not yet", W'(rd_mail_valid), W'(0));
        @(negedge clk); #1;
        check(rd_mail_valid == 1, "R4 valid at S+1", W'(rd_mail_valid), W'(1));

        // R3: write while locked is refused
        wr_en = 1; wr_mb_sel = 1; wr_data = 36'h2_DEAD_BEEF;
        repeat (3) @(negedge clk);
        idle(); #1;
        check(rd_data == 36'h1_1111_2222, "R3 word kept", rd_data, 36'h1_1111_2222);

        // R6/R7: FIFO reads do not consume; mux shows fifo_q
        rd_mb_sel = 0; rd_en = 1; fifo_q = 36'h3_0F0F_0F0F;
        repeat (3) @(negedge clk);
        #1;
        check(rd_data == 36'h3_0F0F_0F0F, "R7 fifo path", rd_data, 36'h3_0F0F_0F0F);
        check(rd_mail_valid == 1, "R6 fifo read keeps mail", W'(rd_mail_valid), W'(1));

        // R5: consume, then flag returns after S+1 edges
        rd_mb_sel = 1; rd_en = 1;
        @(negedge clk); rd_en = 0; #1;
        check(rd_mail_valid == 0, "R5 valid cleared", W'(rd_mail_valid), W'(0));
        repeat (S) @(negedge clk);
        #1;
        check(wr_mail_empty == 0, "R5 flag not yet", W'(wr_mail_empty), W'(0));
        @(negedge clk); #1;
        check(wr_mail_empty == 1, "R5 flag back at S+1", W'(wr_mail_empty), W'(1));

        // R6: mailbox read with nothing waiting has no effect
        rd_en = 1; rd_mb_sel = 1;
        repeat (4) @(negedge clk);
        rd_en = 0; #1;
        check(wr_mail_empty == 1 && rd_mail_valid == 0, "R6 empty read",
              W'({wr_mail_empty, rd_mail_valid}), W'(2'b10));

        // sustained pressure on both sides
        for (int k = 0; k < 120; k++) begin
            wr_en = 1; wr_mb_sel = (k % 5) != 4; wr_data = W'(k * 36'h0_0101_0103 + 7);
            rd_en = (k % 3) != 1; rd_mb_sel = (k % 7) != 6;
            fifo_q = W'(k * 36'h0_0F00_0011);
            @(negedge clk);
        end
        idle(); rd_mb_sel = 1;
        wait_valid();
        rd_en = 1; @(negedge clk); rd_en = 0;
        wait_empty();

        // R8: reset while a word is in flight
        wr_en = 1; wr_mb_sel = 1; wr_data = 36'h5_5555_5555;
        @(negedge clk); idle();
        @(negedge clk); rst_n = 0; #1;
        check(wr_mail_empty == 1, "R8 flag after mid reset", W'(wr_mail_empty), W'(1));
        check(rd_mail_valid == 0, "R8 valid after mid reset", W'(rd_mail_valid), W'(0));
        check(rd_data == '0, "R8 mail after mid reset", rd_data, '0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (S + 4) @(negedge clk);
        #1;
        check(rd_mail_valid == 0, "R8 no stale arrival", W'(rd_mail_valid), W'(0));
        // a fresh handshake still works
        wr_en = 1; wr_mb_sel = 1; wr_data = 36'h6_6666_0001;
        @(negedge clk); idle();
        wait_valid(); #1;
        check(rd_data == 36'h6_6666_0001, "R1 after reset", rd_data, 36'h6_6666_0001);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule